// File: doc/BRIEF.md
# Program Fetch Region Splitter

This block sits beside the instruction fetch path and decides, each cycle, whether the current program fetch address belongs to the on-chip 16KB program ROM or must be fetched over the external multiplexed bus. The boundary comes from a small size code held in a protected register. The on-chip window always starts at address 0000h, and its upper end can be cut back to 8KB, 4KB, 2KB or 1KB, or removed entirely.

Software changes the size code through a two-key unlock sequence followed by a short write window. A write that is out of time or that carries an unusable code is dropped, and a one-cycle reject pulse reports it. A dedicated input pin, active low, sends every fetch to the external bus, whatever the register holds. The decode is purely combinational on the fetch request and address, so a new size code applies to the first fetch after the write edge.

Top module: `prog_fetch_split`

## Requirements
- R1: After reset the size code is 5. Fetches to 0000h–3FFFh select the internal ROM, and fetches at 4000h and above go external.
- R2: The size code is written in cfg_wdata[2:0]. Codes 1, 2, 3, 4 and 5 place the on-chip limit at 1KB, 2KB, 4KB, 8KB and 16KB. An address below the limit selects the ROM, and an address at or above it goes external.
- R3: With size code 0, every address from 0000h to FFFFh is fetched externally.
- R4: While ext_only_n is low, rom_sel stays low and every requested fetch drives ext_fetch_n low.
- R5: ext_fetch_n is low exactly when fetch_req is high and the fetch is not served internally. rom_sel and an active ext_fetch_n never occur together, and with fetch_req low both are inactive.
- R6: A size write accepted at a clock edge governs the decode of the very next cycle. The fetch in the cycle of the write still uses the old code.
- R7: Writing AAh and then 55h to the key register (cfg_sel=0) in consecutive cycles opens a write window for the size register (cfg_sel=1). A write in any of the next 4 cycles is accepted.
- R8: A size write made while no window is open leaves the code unchanged, and cfg_reject is high for the one following cycle.
- R9: A write of code 6 or 7 is rejected even inside an open window. The code stays unchanged, cfg_reject pulses, and the window closes.
- R10: An accepted write closes the window, so a second size write that follows it is rejected.
- R11: The window expires, so a size write in the 5th cycle after the 55h key is rejected. An AAh key not directly followed by 55h opens no window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fetch_req | input | 1 | A program fetch is requested this cycle |
| fetch_addr | input | 16 | Program fetch address |
| ext_only_n | input | 1 | Low forces all fetches to the external bus |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | Write target: 0 key register, 1 size register |
| cfg_wdata | input | 8 | Write data (key byte or size code in bits 2:0) |
| rom_sel | output | 1 | Fetch served by internal ROM |
| ext_fetch_n | output | 1 | External fetch strobe, active low |
| cfg_reject | output | 1 | One-cycle pulse after a rejected size write |

## Verification
The hardest condition to reach is the edge of the write window. A write in the 4th cycle after the second key must be taken, and one in the 5th must be refused. An AAh key separated from its 55h by a single idle cycle must open nothing. The stimulus reaches these cases with exact cycle-by-cycle sequences of key writes, idle cycles and size writes. After each write it fetches just below and just above the affected limit, so the only way to see whether the stored code changed is through the ROM-or-external decision at the ports.

// File: rtl/prog_fetch_split.sv
module prog_fetch_split #(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 8,
  parameter int CODE_W    = 3,
  parameter int MAX_CODE  = 5,
  parameter int RST_CODE  = 5,
  parameter int MIN_SHIFT = 10,
  parameter int WIN_LEN   = 4,
  parameter logic [DATA_W-1:0] KEY_A = 8'hAA,
  parameter logic [DATA_W-1:0] KEY_B = 8'h55
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fetch_req,
  input  logic [ADDR_W-1:0] fetch_addr,
  input  logic              ext_only_n,
  input  logic              cfg_we,
  input  logic              cfg_sel,
  input  logic [DATA_W-1:0] cfg_wdata,
  output logic              rom_sel,
  output logic              ext_fetch_n,
  output logic              cfg_reject
);

  localparam int CNT_W = $clog2(WIN_LEN + 1);

  logic [CODE_W-1:0] size_code;
  logic [CNT_W-1:0]  win_cnt;
  logic              key_a_seen;
  logic [ADDR_W:0]   limit;
  logic              below_limit;

  wire key_wr   = cfg_we && !cfg_sel;
  wire size_wr  = cfg_we && cfg_sel;
  wire win_open = (win_cnt != '0);
  wire code_ok  = (cfg_wdata[CODE_W-1:0] <= CODE_W'(MAX_CODE));
  wire accept   = size_wr && win_open && code_ok;
  wire unlock   = key_wr && (cfg_wdata == KEY_B) && key_a_seen;

  always_comb begin
    if (size_code == '0)
      limit = '0;
    else
      limit = (ADDR_W+1)'(1) << (int'(size_code) + MIN_SHIFT - 1);
  end

  assign below_limit = ({1'b0, fetch_addr} < limit);
  assign rom_sel     = fetch_req && ext_only_n && below_limit;
  assign ext_fetch_n = !(fetch_req && !rom_sel);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      size_code  <= CODE_W'(RST_CODE);
      win_cnt    <= '0;
      key_a_seen <= 1'b0;
      cfg_reject <= 1'b0;
    end else begin
      key_a_seen <= key_wr && (cfg_wdata == KEY_A);
      cfg_reject <= size_wr && !accept;
      if (accept)
        size_code <= cfg_wdata[CODE_W-1:0];
      if (unlock)
        win_cnt <= CNT_W'(WIN_LEN);
      else if (size_wr)
        win_cnt <= '0;
      else if (win_open)
        win_cnt <= win_cnt - 1'b1;
    end
  end

  a_r5_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(rom_sel && !ext_fetch_n));
  a_r5_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !fetch_req |-> (!rom_sel && ext_fetch_n));
  a_r4_force_external: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_req && !ext_only_n) |-> (!rom_sel && !ext_fetch_n));
  a_r2_above_rom_external: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_req && fetch_addr >= ADDR_W'(1 << (MAX_CODE + MIN_SHIFT - 1))) |-> !rom_sel);
  a_r8_closed_write_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (size_wr && !win_open) |=> (cfg_reject && $stable(size_code)));
  a_r9_reserved_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (size_wr && (cfg_wdata[CODE_W-1:0] > CODE_W'(MAX_CODE))) |=> (cfg_reject && $stable(size_code) && !win_open));
  a_r6_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (size_code == $past(cfg_wdata[CODE_W-1:0]) && !cfg_reject));
  a_r11_window_bound: assert property (@(posedge clk) disable iff (!rst_n)
    win_cnt <= CNT_W'(WIN_LEN));
  a_r10_window_closes: assert property (@(posedge clk) disable iff (!rst_n)
    size_wr |=> !win_open);

endmodule

// File: tb/prog_fetch_split_bench.sv
module prog_fetch_split_bench;
  localparam int CLK_PERIOD = 10;

  typedef struct {
    logic rom;
    logic strb_n;
    logic rej;
    string tag;
  } exp_t;

  logic clk = 0, rst_n = 0;
  logic fetch_req = 0, ext_only_n = 1, cfg_we = 0, cfg_sel = 0;
  logic [15:0] fetch_addr = '0;
  logic [7:0]  cfg_wdata = '0;
  logic rom_sel, ext_fetch_n, cfg_reject;

  int runs = 0, fails = 0;
  int code = 5;
  logic rej_next = 0;
  bit done = 0;
  exp_t q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  prog_fetch_split u_prog_fetch_split (
    .clk(clk), .rst_n(rst_n), .fetch_req(fetch_req), .fetch_addr(fetch_addr),
    .ext_only_n(ext_only_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .rom_sel(rom_sel), .ext_fetch_n(ext_fetch_n), .cfg_reject(cfg_reject));

  function automatic logic inside_rom(int c, logic [15:0] a);
    if (c == 0) return 1'b0;
    return (int'(a) < (1 << (c + 9)));
  endfunction

  // one cycle: drive at negedge, push expectation; rej is the pulse from the prior write
  task automatic step(input logic we, input logic sel, input logic [7:0] d,
                      input logic req, input logic [15:0] a, input logic force_n,
                      input logic exp_rej, input string tag);
    exp_t e;
    @(negedge clk);
    cfg_we = we; cfg_sel = sel; cfg_wdata = d;
    fetch_req = req; fetch_addr = a; ext_only_n = force_n;
    e.rom = req && force_n && inside_rom(code, a);
    e.strb_n = !(req && !e.rom);
    e.rej = exp_rej;
    e.tag = tag;
    q.push_back(e);
  endtask

  task automatic fetch(input logic [15:0] a, input string tag);
    step(0, 0, 8'h00, 1, a, 1, rej_next, tag);
    rej_next = 0;
  endtask

  task automatic idle(input string tag);
    step(0, 0, 8'h00, 0, 16'h0000, 1, rej_next, tag);
    rej_next = 0;
  endtask

  task automatic key(input logic [7:0] k, input string tag);
    step(1, 0, k, 0, 16'h0000, 1, rej_next, tag);
    rej_next = 0;
  endtask

  task automatic size_write(input logic [7:0] d, input bit ok, input string tag);
    step(1, 1, d, 0, 16'h0000, 1, rej_next, tag);
    rej_next = !ok;
    if (ok) code = int'(d[2:0]);
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      @(negedge clk);
      #2;
      if (q.size() > 0) begin
        e = q.pop_front();
        runs++;
        if (rom_sel !== e.rom || ext_fetch_n !== e.strb_n || cfg_reject !== e.rej) begin
          fails++;
          $display("FAIL %s: rom_sel=%b ext_fetch_n=%b cfg_reject=%b expected %b %b %b",
                   e.tag, rom_sel, ext_fetch_n, cfg_reject, e.rom, e.strb_n, e.rej);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("[TB] %0d tests run, %0d failed", runs, fails);
      $finish;
    end
  end

  initial begin : driver
    repeat (3) @(negedge clk);
    rst_n = 1;
    idle("R1 reset outputs quiet");
    fetch(16'h0000, "R1 bottom internal");
    fetch(16'h3FFF, "R1 top of 16KB internal");
    fetch(16'h4000, "R1 first external");
    fetch(16'hFFFF, "R1 top external");
    idle("R5 no request");
    step(0, 0, 8'h00, 1, 16'h0100, 0, 0, "R4 forced external");
    step(0, 0, 8'h00, 0, 16'h0100, 0, 0, "R5 forced but no request");
    size_write(8'h03, 0, "R8 write with window closed");
    fetch(16'h2000, "R8 reject pulse, code unchanged");
    fetch(16'h0000, "R8 reject lasts one cycle");
    key(8'hAA, "R7 first key");
    key(8'h55, "R7 second key");
    step(1, 1, 8'h03, 1, 16'h1000, 1, 0, "R6 write cycle uses old code");
    code = 3;
    fetch(16'h1000, "R6 new code on next fetch");
    fetch(16'h0FFF, "R2 4KB top internal");
    size_write(8'h05, 0, "R10 second write after accept");
    fetch(16'h1000, "R10 rejected, 4KB still active");
    for (int c = 5; c >= 0; c--) begin
      key(8'hAA, "R7 key");
      key(8'h55, "R7 key");
      size_write(8'(c), 1, "R2 accepted size write");
      if (c == 0) begin
        fetch(16'h0000, "R3 address 0 external");
        fetch(16'hFFFF, "R3 top external");
        fetch(16'h8000, "R3 mid external");
      end else begin
        fetch(16'((1 << (c + 9)) - 1), "R2 last internal");
        fetch(16'(1 << (c + 9)), "R2 first external");
        step(0, 0, 8'h00, 1, 16'h0000, 0, 0, "R4 force overrides code");
      end
    end
    key(8'hAA, "R9 key");
    key(8'h55, "R9 key");
    size_write(8'h06, 0, "R9 reserved code");
    fetch(16'h0000, "R9 rejected, code 0 kept");
    size_write(8'h02, 0, "R9 window closed by reserved write");
    fetch(16'h0000, "R9 still code 0");
    key(8'hAA, "R11 key");
    key(8'h55, "R11 key");
    idle("R11 wait 1");
    idle("R11 wait 2");
    idle("R11 wait 3");
    size_write(8'h04, 1, "R11 write in 4th cycle accepted");
    fetch(16'h1FFF, "R11 8KB active");
    fetch(16'h2000, "R11 8KB limit");
    key(8'hAA, "R11 key");
    key(8'h55, "R11 key");
    idle("R11 wait 1");
    idle("R11 wait 2");
    idle("R11 wait 3");
    idle("R11 wait 4");
    size_write(8'h01, 0, "R11 write in 5th cycle rejected");
    fetch(16'h1FFF, "R11 timeout keeps 8KB");
    key(8'hAA, "R11 split key");
    idle("R11 gap");
    key(8'h55, "R11 late second key");
    size_write(8'h02, 0, "R11 no window opened");
    fetch(16'h1FFF, "R11 still 8KB");
    idle("R5 final quiet");
    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end
endmodule